// File: doc/BRIEF.md
# Interrupt Source Router with Pending Tracking

The block takes level-change events from seven interrupt causes and routes each one, through one of six vector registers, onto a bank of output request lines. Each vector register holds a destination, a priority and a source-line select. When a cause changes level, the block updates that cause's status bit, raises or lowers the output line that the vector selects, and rewrites the vector's pending bit. Two link causes share the first vector register and its output line. That line is released only when both of them are idle. A priority of all ones masks a vector: its pending bit then stays clear, but the output line is still driven.

Software reaches the vector registers, the two status registers and a compare register through a single-cycle write port and a combinational read port. Every vector write sends a configuration pulse downstream: the destination with its two link-pointer bits removed, plus the priority and the source select. The compare register supplies the base offset for downstream source numbering.

Top module: `irq_vector_router`

## Requirements
- R1: After reset, vector k (k = 0..5) reads with priority 0xFF, source select k, destination 0 and pending 0. All output lines, status bits, the compare register and `err` are 0.
- R2: Reads from any unmapped address return all ones. Writes to the status registers (0x0E, 0x15) or to unmapped addresses change no register, line or output. Vector registers sit at 0x10 (vector 0) and 0x16..0x1A (vectors 1..5), and the compare register sits at 0x1B.
- R3: A cause that asserts sets its status bit. Causes 0 and 1 use bits 47 and 46 of register 0x0E. Cause c (2..6) uses bit 38-c of register 0x15. One cycle after the event, the output line chosen by the cause's vector goes high. Causes 0 and 1 map to vector 0, and cause c (2..6) maps to vector c-1.
- R4: A cause from 2..6 that deasserts clears its status bit and lowers its vector's output line one cycle later.
- R5: When cause 0 or cause 1 deasserts, the shared line is lowered only if neither bit 47 nor bit 46 remains set. Otherwise the event counts as still active, and both the line and the pending bit stay high.
- R6: After each event, the vector's pending bit (bit 24) is 1 if the event is still active and the priority is not 0xFF, and 0 otherwise. A masked vector still drives its line.
- R7: A vector write stores destination [55:40], priority [39:32] and source select [31:29], and keeps the current pending bit. It clears pending if the new priority is 0xFF. All other bits read back as 0.
- R8: One cycle after a vector write with a source select of 6 or less, `cfg_valid` pulses for one cycle with `cfg_dest` equal to the written destination shifted right by 2, plus the written priority and source select.
- R9: A compare write keeps bits [63:45] and [35:32] and clears the rest. `base_offset` equals the stored [63:45] field.
- R10: A cause index of 7 changes nothing and pulses `err` one cycle later. A vector write with source select 7 is stored, but it produces no `cfg_valid` and pulses `err`. An event on a vector whose source select is 7 updates status and pending, leaves all lines unchanged and pulses `err`.
- R11: When a vector write and an event on the same vector arrive in the same cycle, the event uses the newly written priority and source select.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cause_valid | input | 1 | A cause level-change event is present this cycle |
| cause_idx | input | 3 | Index of the cause that changed |
| cause_level | input | 1 | New level of that cause |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register index for reads and writes |
| reg_wdata | input | 64 | Write data |
| reg_rdata | output | 64 | Combinational read data for `reg_addr` |
| line_out | output | 7 | Output request lines |
| base_offset | output | 19 | Source-number base taken from the compare register |
| cfg_valid | output | 1 | One-cycle pulse after an accepted vector write |
| cfg_dest | output | 14 | Written destination with the link-pointer bits removed |
| cfg_prio | output | 8 | Written priority |
| cfg_src | output | 3 | Written source select |
| err | output | 1 | One-cycle pulse after an out-of-range cause or source select |

## Verification
The assertions assume at most one cause event per cycle. The line-following checks are limited to cycles without a register write, so that a same-cycle reconfiguration cannot move the target line under them. The stimulus sends every cause change as a single-cycle event that never overlaps a write, except in the one deliberate same-cycle case for R11. The stimulus also restores every vector to a valid source select before it drives further events.

// File: rtl/irq_vector_router.sv
module irq_vector_router #(
  parameter int NUM_LINES = 7,
  parameter int ADDR_W    = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cause_valid,
  input  logic [2:0]        cause_idx,
  input  logic              cause_level,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [63:0]       reg_wdata,
  output logic [63:0]       reg_rdata,
  output logic [NUM_LINES-1:0] line_out,
  output logic [18:0]       base_offset,
  output logic              cfg_valid,
  output logic [13:0]       cfg_dest,
  output logic [7:0]        cfg_prio,
  output logic [2:0]        cfg_src,
  output logic              err
);
  localparam int NUM_VEC   = 6;
  localparam int NUM_CAUSE = 7;
  localparam int SRC_W     = 3;
  localparam int DEST_W    = 16;
  localparam int PRIO_W    = 8;
  localparam int CMP_W     = 19;
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(6'h0E);
  localparam logic [ADDR_W-1:0] A_VEC0 = ADDR_W'(6'h10);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(6'h15);
  localparam logic [ADDR_W-1:0] A_VEC1 = ADDR_W'(6'h16);
  localparam logic [ADDR_W-1:0] A_VEC5 = ADDR_W'(6'h1A);
  localparam logic [ADDR_W-1:0] A_CMP  = ADDR_W'(6'h1B);

  logic [NUM_VEC-1:0][DEST_W-1:0] dest_q, dest_n;
  logic [NUM_VEC-1:0][PRIO_W-1:0] prio_q, prio_n;
  logic [NUM_VEC-1:0][SRC_W-1:0]  src_q,  src_n;
  logic [NUM_VEC-1:0]             pend_q, pend_n;
  logic [1:0]                     link_q, link_n;
  logic [4:0]                     stat_q, stat_n;
  logic [CMP_W-1:0]               cmp_q,  cmp_n;
  logic [3:0]                     flg_q,  flg_n;
  logic [NUM_LINES-1:0]           line_q, line_n;
  logic                           err_n, cfgv_n;

  logic       wv_hit, rv_hit;
  logic [2:0] wv_idx, rv_idx, ev_vec, sbit;
  logic       ev_active;
  logic [SRC_W-1:0] wsrc;
  logic       unused_wdata;

  function automatic logic [3:0] vec_of(input logic [ADDR_W-1:0] a);
    if (a == A_VEC0) return 4'b1000;
    if (a >= A_VEC1 && a <= A_VEC5) return {1'b1, 3'(a - A_VEC1 + 1'b1)};
    return 4'b0000;
  endfunction

  assign {wv_hit, wv_idx} = vec_of(reg_addr);
  assign {rv_hit, rv_idx} = vec_of(reg_addr);
  assign wsrc   = reg_wdata[31:29];
  assign ev_vec = (cause_idx < 3'd2) ? 3'd0 : cause_idx - 3'd1;
  assign sbit   = 3'd6 - cause_idx;
  assign unused_wdata = ^reg_wdata[28:0];

  always_comb begin
    dest_n = dest_q; prio_n = prio_q; src_n = src_q; pend_n = pend_q;
    link_n = link_q; stat_n = stat_q; cmp_n = cmp_q; flg_n = flg_q;
    line_n = line_q; err_n = 1'b0; cfgv_n = 1'b0; ev_active = 1'b0;
    if (reg_wr && wv_hit) begin
      dest_n[wv_idx] = reg_wdata[55:40];
      prio_n[wv_idx] = reg_wdata[39:32];
      src_n[wv_idx]  = wsrc;
      if (&reg_wdata[39:32]) pend_n[wv_idx] = 1'b0;
      if (32'(wsrc) >= NUM_LINES) err_n = 1'b1;
      else cfgv_n = 1'b1;
    end
    if (reg_wr && reg_addr == A_CMP) begin
      cmp_n = reg_wdata[63:45];
      flg_n = reg_wdata[35:32];
    end
    if (cause_valid) begin
      if (32'(cause_idx) >= NUM_CAUSE) begin
        err_n = 1'b1;
      end else begin
        ev_active = cause_level;
        if (cause_idx < 3'd2) begin
          link_n[~cause_idx[0]] = cause_level;
          if (!cause_level && |link_n) ev_active = 1'b1;
        end else begin
          stat_n[sbit] = cause_level;
        end
        if (32'(src_n[ev_vec]) >= NUM_LINES) err_n = 1'b1;
        else if (cause_level) line_n[src_n[ev_vec]] = 1'b1;
        else if (!ev_active) line_n[src_n[ev_vec]] = 1'b0;
        pend_n[ev_vec] = ev_active && !(&prio_n[ev_vec]);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_VEC; i++) begin
        dest_q[i] <= '0;
        prio_q[i] <= '1;
        src_q[i]  <= SRC_W'(i);
      end
      pend_q <= '0; link_q <= '0; stat_q <= '0;
      cmp_q <= '0; flg_q <= '0; line_q <= '0;
      err <= 1'b0; cfg_valid <= 1'b0;
      cfg_dest <= '0; cfg_prio <= '0; cfg_src <= '0;
    end else begin
      dest_q <= dest_n; prio_q <= prio_n; src_q <= src_n; pend_q <= pend_n;
      link_q <= link_n; stat_q <= stat_n; cmp_q <= cmp_n; flg_q <= flg_n;
      line_q <= line_n; err <= err_n; cfg_valid <= cfgv_n;
      if (cfgv_n) begin
        cfg_dest <= reg_wdata[55:42];
        cfg_prio <= reg_wdata[39:32];
        cfg_src  <= wsrc;
      end
    end
  end

  always_comb begin
    reg_rdata = '1;
    if (rv_hit)
      reg_rdata = {8'h00, dest_q[rv_idx], prio_q[rv_idx], src_q[rv_idx],
                   4'h0, pend_q[rv_idx], 24'h0};
    else if (reg_addr == A_CTRL)
      reg_rdata = {16'h0, link_q, 46'h0};
    else if (reg_addr == A_STAT)
      reg_rdata = {27'h0, stat_q, 32'h0};
    else if (reg_addr == A_CMP)
      reg_rdata = {cmp_q, 9'h0, flg_q, 32'h0};
  end

  assign line_out    = line_q;
  assign base_offset = cmp_q;
endmodule

module irq_vector_router_chk #(
  parameter int NUM_LINES = 7
) (
  input logic       clk,
  input logic       rst_n,
  input logic       cause_valid,
  input logic [2:0] cause_idx,
  input logic       cause_level,
  input logic       reg_wr,
  input logic [NUM_LINES-1:0] line_out,
  input logic       cfg_valid,
  input logic [2:0] cfg_src,
  input logic       err,
  input logic [5:0][7:0] prio_q,
  input logic [5:0][2:0] src_q,
  input logic [5:0] pend_q,
  input logic [1:0] link_q,
  input logic [4:0] stat_q
);
  for (genvar v = 0; v < 6; v++) begin : g_vec
    // R6
    masked_never_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pend_q[v] |-> prio_q[v] != 8'hFF);
  end

  // R3
  link_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cause_valid && cause_level && cause_idx < 3'd2 && !reg_wr &&
     32'(src_q[0]) < NUM_LINES) |=> line_out[$past(src_q[0])]);

  // R5
  shared_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cause_valid && !cause_level && cause_idx < 3'd2 && link_q == 2'b11 &&
     !reg_wr && 32'(src_q[0]) < NUM_LINES) |=> line_out[$past(src_q[0])]);

  // R8
  cfg_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_valid |-> $past(reg_wr) && 32'(cfg_src) < NUM_LINES);

  // R10
  bad_cause_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cause_valid && cause_idx == 3'd7) |=> err);

  // R2
  status_readonly_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && !cause_valid) |=> $stable(stat_q) && $stable(link_q));
endmodule

bind irq_vector_router irq_vector_router_chk #(.NUM_LINES(NUM_LINES)) chk (
  .clk(clk), .rst_n(rst_n), .cause_valid(cause_valid), .cause_idx(cause_idx),
  .cause_level(cause_level), .reg_wr(reg_wr), .line_out(line_out),
  .cfg_valid(cfg_valid), .cfg_src(cfg_src), .err(err),
  .prio_q(prio_q), .src_q(src_q), .pend_q(pend_q), .link_q(link_q),
  .stat_q(stat_q)
);

// File: tb/tb_irq_vector_router.sv
module tb_irq_vector_router;
  logic clk = 0, rst_n = 0;
  logic cause_valid = 0, cause_level = 0, reg_wr = 0;
  logic [2:0] cause_idx = 0;
  logic [5:0] reg_addr = 0;
  logic [63:0] reg_wdata = 0, reg_rdata;
  logic [6:0] line_out;
  logic [18:0] base_offset;
  logic cfg_valid, err;
  logic [13:0] cfg_dest;
  logic [7:0] cfg_prio;
  logic [2:0] cfg_src;
  int tests = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  irq_vector_router dut (.*);

  function automatic logic [5:0] va(int v);
    return (v == 0) ? 6'h10 : 6'(6'h15 + v);
  endfunction

  function automatic logic [63:0] vv(logic [15:0] d, logic [7:0] p, logic [2:0] s, logic pd);
    return {8'h0, d, p, s, 4'h0, pd, 24'h0};
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(logic [5:0] a, output logic [63:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic wr(logic [5:0] a, logic [63:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic ev(int c, logic lvl);
    @(negedge clk); cause_valid = 1; cause_idx = 3'(c); cause_level = lvl;
    @(negedge clk); cause_valid = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [63:0] d;
    logic [15:0] ds;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset values
    for (int v = 0; v < 6; v++) begin
      rd(va(v), d); check("R1 vector", d, vv(16'h0, 8'hFF, 3'(v), 1'b0));
    end
    check("R1 lines", {57'h0, line_out}, 64'h0);
    check("R1 err/base", {44'h0, err, base_offset}, 64'h0);
    rd(6'h0E, d); check("R1 ctrl", d, 64'h0);
    rd(6'h15, d); check("R1 stat", d, 64'h0);
    // R2 unmapped sweep
    for (int a = 0; a < 64; a++) begin
      if (!(a == 'h0E || a == 'h10 || a == 'h15 || (a >= 'h16 && a <= 'h1B))) begin
        rd(6'(a), d); check("R2 unmapped read", d, '1);
      end
    end
    wr(6'h15, '1); rd(6'h15, d); check("R2 stat write ignored", d, 64'h0);
    wr(6'h0E, '1); rd(6'h0E, d); check("R2 ctrl write ignored", d, 64'h0);
    wr(6'h03, '1); check("R2 lines after writes", {57'h0, line_out}, 64'h0);
    check("R2 no cfg", {63'h0, cfg_valid}, 64'h0);
    // R7/R8 configure vectors
    for (int v = 0; v < 6; v++) begin
      ds = 16'h1003 + 16'(v) * 16'h0104;
      wr(va(v), vv(ds, 8'(v), 3'(v), 1'b1) | 64'hFF00_0000_1EFF_FFFF);
      check("R8 cfg_valid", {63'h0, cfg_valid}, 64'h1);
      check("R8 cfg_dest", {50'h0, cfg_dest}, {50'h0, ds[15:2]});
      check("R8 cfg_prio/src", {53'h0, cfg_prio, cfg_src}, {53'h0, 8'(v), 3'(v)});
      rd(va(v), d); check("R7 readback", d, vv(ds, 8'(v), 3'(v), 1'b0));
    end
    // R3/R4/R6 causes 2..6
    for (int c = 2; c < 7; c++) begin
      ev(c, 1'b1);
      rd(6'h15, d); check("R3 status set", d, 64'h1 << (38 - c));
      check("R3 line high", {57'h0, line_out}, 64'h1 << (c - 1));
      rd(va(c - 1), d); check("R6 pending set", {63'h0, d[24]}, 64'h1);
      ev(c, 1'b0);
      rd(6'h15, d); check("R4 status clear", d, 64'h0);
      check("R4 line low", {57'h0, line_out}, 64'h0);
      rd(va(c - 1), d); check("R6 pending clear", {63'h0, d[24]}, 64'h0);
    end
    // R5 shared link causes, both release orders
    for (int f = 0; f < 2; f++) begin
      ev(0, 1'b1);
      rd(6'h0E, d); check("R3 link bit47", d, 64'h1 << 47);
      check("R3 link line", {57'h0, line_out}, 64'h1);
      ev(1, 1'b1);
      rd(6'h0E, d); check("R3 both link bits", d, 64'h3 << 46);
      ev(f, 1'b0);
      check("R5 line held", {57'h0, line_out}, 64'h1);
      rd(va(0), d); check("R5 pending held", {63'h0, d[24]}, 64'h1);
      ev(1 - f, 1'b0);
      check("R5 line released", {57'h0, line_out}, 64'h0);
      rd(va(0), d); check("R5 pending cleared", {63'h0, d[24]}, 64'h0);
    end
    // R6 masked vector still drives its line
    wr(va(1), vv(16'h0, 8'hFF, 3'd1, 1'b0));
    ev(2, 1'b1);
    check("R6 masked line", {57'h0, line_out}, 64'h2);
    rd(va(1), d); check("R6 masked no pending", {63'h0, d[24]}, 64'h0);
    ev(2, 1'b0);
    // R7 pending kept across write, cleared by mask
    ev(3, 1'b1);
    wr(va(2), vv(16'hBEEF, 8'h07, 3'd2, 1'b0));
    rd(va(2), d); check("R7 pending kept", d, vv(16'hBEEF, 8'h07, 3'd2, 1'b1));
    wr(va(2), vv(16'hBEEF, 8'hFF, 3'd2, 1'b1));
    rd(va(2), d); check("R7 mask clears pending", d, vv(16'hBEEF, 8'hFF, 3'd2, 1'b0));
    check("R7 line unchanged", {57'h0, line_out}, 64'h4);
    ev(3, 1'b0);
    // R9 compare register
    wr(6'h1B, '1);
    rd(6'h1B, d); check("R9 compare readback", d, 64'hFFFF_E00F_0000_0000);
    check("R9 base all ones", {45'h0, base_offset}, 64'h7FFFF);
    for (int k = 0; k < 19; k++) begin
      wr(6'h1B, 64'h1 << (45 + k));
      check("R9 base bit", {45'h0, base_offset}, 64'h1 << k);
    end
    // R10 errors
    ev(7, 1'b1);
    check("R10 bad cause err", {63'h0, err}, 64'h1);
    check("R10 bad cause lines", {57'h0, line_out}, 64'h0);
    rd(6'h15, d); check("R10 bad cause status", d, 64'h0);
    wr(va(3), vv(16'h0, 8'h01, 3'd7, 1'b0));
    check("R10 bad src err/cfg", {62'h0, err, cfg_valid}, 64'h2);
    rd(va(3), d); check("R10 bad src stored", d, vv(16'h0, 8'h01, 3'd7, 1'b0));
    ev(4, 1'b1);
    check("R10 event err", {63'h0, err}, 64'h1);
    check("R10 event lines", {57'h0, line_out}, 64'h0);
    rd(6'h15, d); check("R10 event status", d, 64'h1 << 34);
    ev(4, 1'b0);
    wr(va(3), vv(16'h0, 8'h03, 3'd3, 1'b0));
    // R11 same-cycle write and event
    @(negedge clk);
    reg_wr = 1; reg_addr = va(4); reg_wdata = vv(16'h0, 8'h03, 3'd6, 1'b0);
    cause_valid = 1; cause_idx = 3'd5; cause_level = 1;
    @(negedge clk); reg_wr = 0; cause_valid = 0;
    check("R11 new line", {57'h0, line_out}, 64'h40);
    rd(va(4), d); check("R11 pending", d, vv(16'h0, 8'h03, 3'd6, 1'b1));
    ev(5, 1'b0);
    check("R11 line low", {57'h0, line_out}, 64'h0);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule